// File: doc/BRIEF.md
# Interleaved Two-Phase Drive Sequencer

This block sequences the gate-drive enables of a two-branch boost converter whose branches run out of phase. One stream of oscillator ticks is split between the branches: the first tick after reset goes to phase 1, the next to phase 2, and so on. Each drive output therefore switches at half the tick rate, and the two branches stay half a period apart.

A phase turns on only when two conditions hold: its own tick has arrived, and its inductor has demagnetized. Demagnetization is reported by a falling edge of that phase's zero-current comparator bit. When demagnetization finishes before the next tick, the phase waits for that tick. The waiting time is dead time, and the switching frequency is clamped. When a tick arrives before demagnetization finishes, the phase remembers the tick and turns on at the zero-current edge with no dead time.

Each pulse lasts a programmed number of clock cycles. It ends early when a global stop is raised. A per-phase watchdog treats a missing zero-current edge as demagnetization once a set time has passed. A skip input suppresses new pulses. A status bit per phase tells whether the latest pulse followed dead time.

Each phase is a three-state machine:
- `PH_READY`: demagnetized, waiting for a tick. It moves to `PH_ON` when its tick arrives and starting is allowed.
- `PH_ON`: the drive is high. It moves to `PH_DEMAG` when the on-time count completes or stop is raised.
- `PH_DEMAG`: waiting for demagnetization. When the zero-current edge arrives or the watchdog expires, it moves to `PH_ON` if a tick is held and starting is allowed, and to `PH_READY` otherwise.

Top module: `ilv_drive_seq`

## Requirements
- R1: Ticks are steered alternately: the first tick after reset goes to phase 1, and each following tick goes to the other phase. Every tick is steered to exactly one phase, including ticks that produce no pulse.
- R2: A phase turns on only in the cycle after one of two events: its own tick (while in `PH_READY`), or the end of demagnetization (while in `PH_DEMAG` with a held tick). The end of demagnetization is a zero-current edge or watchdog expiry.
- R3: A zero-current event is a high-to-low transition of that phase's bit in `zcd` (bit 0 is phase 1, bit 1 is phase 2). It is taken only while the phase is in `PH_DEMAG`.
- R4: A tick that arrives while the phase is on or demagnetizing is held. The phase then starts at the end of demagnetization with no dead time, and its `cyc_dcm` bit reads 0. A pulse started by a tick in `PH_READY` sets the bit to 1 (bit 0 is phase 1).
- R5: If no zero-current edge comes within `WD_CYC` cycles of entering `PH_DEMAG`, the phase treats itself as demagnetized. It then restarts at once if a tick is held.
- R6: Stop is reset-dominant. While `stop` is high, no pulse starts. A pulse that sees `stop` ends at the next edge, so each drive is low in the cycle after any cycle in which `stop` is high.
- R7: A pulse holds its drive high for exactly the `ton_val` cycles captured when it starts. A tick that arrives while `ton_val` is 0 is used up without producing a pulse.
- R8: While `skip` is high, a tick produces no pulse and is not held, but tick steering keeps alternating. Pulses resume on ticks that arrive after `skip` falls.
- R9: After reset, both drives are low, both `cyc_dcm` bits are 0, and both phases are in `PH_READY`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| osc_tick | input | 1 | One-cycle oscillator tick |
| zcd | input | 2 | Zero-current comparator bits, high while demagnetizing (bit 0 is phase 1) |
| ton_val | input | TON_W | On-time in clock cycles |
| stop | input | 1 | Global stop, reset-dominant |
| skip | input | 1 | Suppress new pulses |
| drv1 | output | 1 | Phase 1 gate-drive enable |
| drv2 | output | 1 | Phase 2 gate-drive enable |
| cyc_dcm | output | 2 | 1 means the latest pulse followed dead time (bit 0 is phase 1) |

## Verification
The bench builds the block with `TON_W` = 8 and `WD_CYC` = 40 instead of the default 40000 (about 200 µs at 200 MHz). The short watchdog lets a run reach the missing-edge restart of R5 within a few dozen cycles. The 8-bit on-time allows pulses long enough to be cut short by stop.

A behavioural model of the inductor raises a phase's comparator bit when its drive falls and releases it after a chosen demagnetization delay. Setting a short delay with sparse ticks gives the dead-time case; setting a long delay with dense ticks gives the held-tick case. The model can also suppress the zero-current edge entirely, which exercises the watchdog.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    typedef enum logic [1:0] {
        PH_READY = 2'd0,
        PH_ON    = 2'd1,
        PH_DEMAG = 2'd2
    } ph_state_t;
endpackage

// File: rtl/ilv_tick_steer.sv
module ilv_tick_steer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    output logic [1:0] tick_ph
);
    logic sel;  // 0: next tick goes to phase 1

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sel <= 1'b0;
        else if (osc_tick) sel <= ~sel;
    end

    assign tick_ph[0] = osc_tick & ~sel;
    assign tick_ph[1] = osc_tick &  sel;

    AST_TICK_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        osc_tick |=> (sel != $past(sel))); // R1
    AST_TICK_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        osc_tick |-> $countones(tick_ph) == 1); // R1
endmodule

// File: rtl/ilv_zcd_edge.sv
module ilv_zcd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic zcd_bit,
    output logic zfall
);
    logic zcd_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) zcd_d <= 1'b0;
        else        zcd_d <= zcd_bit;
    end

    assign zfall = zcd_d & ~zcd_bit;
endmodule

// File: rtl/ilv_phase_ctl.sv
module ilv_phase_ctl
    import ilv_pkg::*;
#(
    parameter int TON_W  = 8,
    parameter int WD_CYC = 40000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             zfall,
    input  logic [TON_W-1:0] ton_val,
    input  logic             stop,
    input  logic             skip,
    output logic             drv,
    output logic             dcm
);
    localparam int WD_W = $clog2(WD_CYC + 1);
    localparam logic [WD_W-1:0] WD_LAST = WD_W'(WD_CYC - 1);

    ph_state_t        state, nxt;
    logic [TON_W-1:0] cnt, ton_q;
    logic [WD_W-1:0]  wd_cnt;
    logic             pend;
    logic             go, demag_done, want, start_rdy, start_crm;

    always_comb begin
        go         = !stop && !skip && (ton_val != '0);
        demag_done = zfall || (wd_cnt == WD_LAST);
        want       = pend || (tick && !skip);
        nxt        = state;
        unique case (state)
            PH_READY: if (tick && go) nxt = PH_ON;
            PH_ON:    if (stop || (cnt == ton_q - 1'b1)) nxt = PH_DEMAG;
            PH_DEMAG: if (demag_done) nxt = (want && go) ? PH_ON : PH_READY;
            default:  nxt = PH_READY;
        endcase
        start_rdy = (state == PH_READY) && (nxt == PH_ON);
        start_crm = (state == PH_DEMAG) && (nxt == PH_ON);
    end

    // state register and its counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= PH_READY;
            cnt    <= '0;
            ton_q  <= '0;
            wd_cnt <= '0;
            pend   <= 1'b0;
        end else begin
            state <= nxt;
            if (start_rdy || start_crm) begin
                cnt   <= '0;
                ton_q <= ton_val;
            end else if (state == PH_ON) begin
                cnt <= cnt + 1'b1;
            end
            if (state != PH_DEMAG) wd_cnt <= '0;
            else if (wd_cnt != WD_LAST) wd_cnt <= wd_cnt + 1'b1;
            if (state == PH_READY || nxt == PH_READY || start_crm) pend <= 1'b0;
            else if (tick && !skip) pend <= 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv <= 1'b0;
            dcm <= 1'b0;
        end else begin
            drv <= (nxt == PH_ON);
            if (start_rdy)      dcm <= 1'b1;
            else if (start_crm) dcm <= 1'b0;
        end
    end

    AST_STOP_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !drv); // R6
    AST_SKIP_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv) |-> !$past(skip)); // R8
    AST_ZERO_TON_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv) |-> ($past(ton_val) != '0)); // R7
    AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv) |-> $past(tick || zfall || (wd_cnt == WD_LAST))); // R2
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_ON) |-> (cnt < ton_q)); // R7
endmodule

// File: rtl/ilv_drive_seq.sv
module ilv_drive_seq #(
    parameter int TON_W  = 8,
    parameter int WD_CYC = 40000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic [1:0]       zcd,
    input  logic [TON_W-1:0] ton_val,
    input  logic             stop,
    input  logic             skip,
    output logic             drv1,
    output logic             drv2,
    output logic [1:0]       cyc_dcm
);
    logic [1:0] tick_ph, zfall, drv;

    ilv_tick_steer u_steer (
        .clk     (clk),
        .rst_n   (rst_n),
        .osc_tick(osc_tick),
        .tick_ph (tick_ph)
    );

    for (genvar p = 0; p < 2; p++) begin : g_ph
        ilv_zcd_edge u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .zcd_bit(zcd[p]),
            .zfall  (zfall[p])
        );
        ilv_phase_ctl #(.TON_W(TON_W), .WD_CYC(WD_CYC)) u_ctl (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick_ph[p]),
            .zfall  (zfall[p]),
            .ton_val(ton_val),
            .stop   (stop),
            .skip   (skip),
            .drv    (drv[p]),
            .dcm    (cyc_dcm[p])
        );
    end

    assign drv1 = drv[0];
    assign drv2 = drv[1];
endmodule

// File: tb/sim_ilv_drive_seq.sv
`timescale 1ns/1ps
module sim_ilv_drive_seq;
    localparam int TON_W = 8;
    localparam int WD_CYC = 40;

    typedef struct {
        string req;
        int    ph;
        int    len;
        int    dcm;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             osc_tick = 1'b0;
    logic [1:0]       zcd = 2'b00;
    logic [TON_W-1:0] ton_val = 8'd5;
    logic             stop = 1'b0;
    logic             skip = 1'b0;
    logic             drv1, drv2;
    logic [1:0]       cyc_dcm;

    int   checks = 0;
    int   errors = 0;
    int   rises = 0;
    exp_t expq[$];
    int   demag_len[2];
    bit   no_zcd[2];
    bit   finished = 0;

    always #2.5 clk = ~clk;

    ilv_drive_seq #(.TON_W(TON_W), .WD_CYC(WD_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .zcd(zcd),
        .ton_val(ton_val), .stop(stop), .skip(skip),
        .drv1(drv1), .drv2(drv2), .cyc_dcm(cyc_dcm)
    );

    task automatic chk(input string req, input int act, input int expv, input string what);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) osc_tick = 1'b1;
        @(negedge clk) osc_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input string req, input int ph, input int len, input int dcm);
        exp_t e;
        e.req = req; e.ph = ph; e.len = len; e.dcm = dcm;
        expq.push_back(e);
    endtask

    // inductor model: comparator bit high from drive fall for demag_len cycles
    logic [1:0] zm_prev = 2'b00;
    int         zm_cnt[2] = '{0, 0};
    always @(negedge clk) begin
        logic [1:0] d;
        d = {drv2, drv1};
        for (int p = 0; p < 2; p++) begin
            if (zm_prev[p] && !d[p]) begin
                if (!no_zcd[p]) begin
                    zcd[p] = 1'b1;
                    zm_cnt[p] = demag_len[p];
                end
            end else if (zm_cnt[p] > 0) begin
                zm_cnt[p]--;
                if (zm_cnt[p] == 0) zcd[p] = 1'b0;
            end
        end
        zm_prev = d;
    end

    // monitor / scoreboard
    logic [1:0] mon_prev = 2'b00;
    int         mon_len[2] = '{0, 0};
    int         mon_dcm[2] = '{0, 0};
    always @(negedge clk) begin
        logic [1:0] d;
        exp_t e;
        d = {drv2, drv1};
        if (rst_n) begin
            for (int p = 0; p < 2; p++) begin
                if (d[p] && !mon_prev[p]) begin
                    rises++;
                    mon_len[p] = 1;
                    mon_dcm[p] = int'(cyc_dcm[p]);
                end else if (d[p]) begin
                    mon_len[p]++;
                end else if (mon_prev[p]) begin
                    if (expq.size() == 0) begin
                        chk("R2", p + 1, 0, "unexpected pulse on phase");
                    end else begin
                        e = expq.pop_front();
                        chk("R1", p + 1, e.ph, {e.req, " pulse phase"});
                        chk(e.req, mon_len[p], e.len, "pulse length");
                        chk(e.req, mon_dcm[p], e.dcm, "dead-time status");
                    end
                end
            end
        end
        mon_prev = d;
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        int r0;
        demag_len = '{3, 3};
        no_zcd = '{0, 0};
        idle(5);
        // R9 reset state
        chk("R9", int'(drv1), 0, "drv1 in reset");
        chk("R9", int'(drv2), 0, "drv2 in reset");
        chk("R9", int'(cyc_dcm), 0, "cyc_dcm in reset");
        rst_n = 1'b1;
        idle(3);
        chk("R9", int'({drv2, drv1}), 0, "drives after reset");

        // dead-time operation, R4 and R7 with two on-times
        ton_val = 8'd5;
        for (int i = 0; i < 4; i++) begin
            push("R4", (i % 2) + 1, 5, 1);
            do_tick();
            idle(30);
        end
        ton_val = 8'd2;
        push("R7", 1, 2, 1); do_tick(); idle(30);
        push("R7", 2, 2, 1); do_tick(); idle(30);

        // critical conduction: held ticks, R3 and R4
        ton_val = 8'd4;
        demag_len = '{20, 20};
        push("R4", 1, 4, 1);
        push("R4", 2, 4, 1);
        push("R3", 1, 4, 0);
        push("R3", 2, 4, 0);
        push("R4", 1, 4, 0);
        push("R4", 2, 4, 0);
        for (int i = 0; i < 6; i++) begin
            do_tick();
            idle(9);
        end
        idle(80);

        // missing zero-current edge on phase 1, R5
        demag_len = '{3, 3};
        no_zcd[0] = 1;
        ton_val = 8'd3;
        push("R5", 1, 3, 1); do_tick(); idle(4);
        push("R5", 2, 3, 1); do_tick(); idle(4);
        push("R5", 1, 3, 0); do_tick(); idle(20);
        chk("R5", int'(drv1), 0, "phase 1 waits for watchdog");
        idle(40);
        push("R5", 2, 3, 1); do_tick(); idle(30);
        no_zcd[0] = 0;
        idle(60);

        // skip, R8
        r0 = rises;
        skip = 1'b1;
        do_tick(); idle(10);
        do_tick(); idle(10);
        chk("R8", rises - r0, 0, "pulses while skip high");
        skip = 1'b0;
        push("R8", 1, 3, 1); do_tick(); idle(30);
        push("R8", 2, 3, 1); do_tick(); idle(30);

        // stop, R6
        r0 = rises;
        stop = 1'b1;
        do_tick();
        stop = 1'b0;
        idle(10);
        chk("R6", rises - r0, 0, "pulse with stop on tick");
        ton_val = 8'd20;
        push("R6", 2, 5, 1);
        do_tick();
        idle(4);
        stop = 1'b1;
        @(negedge clk) stop = 1'b0;
        idle(30);

        // zero on-time, R7
        r0 = rises;
        ton_val = 8'd0;
        do_tick(); idle(10);
        chk("R7", rises - r0, 0, "pulse with zero on-time");
        ton_val = 8'd3;
        push("R7", 2, 3, 1); do_tick(); idle(30);

        chk("R2", expq.size(), 0, "expected pulses left unseen");
        finished = 1;
        finish_run();
    end
endmodule